// File: doc/BRIEF.md
# Three-Step Search Motion Estimator

The block finds the motion vector of one 16x16 current-frame block inside a 32x32 search window taken from the previous frame. It uses the three-step search. In the first step the block evaluates the zero-displacement centre and eight neighbours four pixels away. The best of those nine positions becomes the new centre. The next two steps repeat the process at distances of two pixels and then one pixel. The reachable range is therefore ±7 pixels in each direction.

Nine sum-of-absolute-differences units work side by side. In every cycle one current-block pixel is read and broadcast to all nine units, and each unit compares it with its own search-window pixel. A step takes exactly 256 cycles and a full search takes 768 cycles.

The search window is held in nine separately addressed single-port banks. Consecutive pixels along each axis rotate through three banks, in a 3x3 tiling. Because of this layout, the nine candidates of any step always need nine different banks in the same cycle.

A search is started with a one-cycle `start_i` pulse. When it ends, a one-cycle `done_o` pulse marks a new motion vector and its SAD on the outputs.

Top module: `tss_me`

## Requirements
- R1: After reset `done_o` is 0 and `mv_x_o`, `mv_y_o` and `sad_o` are all 0.
- R2: A `start_i` seen high on a clock edge while idle starts a search. `done_o` is high for exactly one cycle, following the 768th rising edge after the accepting edge. This gives three steps of 256 cycles each.
- R3: In the n-th cycle of a search (n counted from 0), `cur_addr_o` equals n mod 256. The address encodes row*16+col, so the block is read in raster order, and the pixel returned in that cycle is used by all nine candidates.
- R4: The three steps use distances s = 4, 2 and 1. Step candidates sit at the centre plus (ox*s, oy*s). The SAD of displacement (dx,dy) is the sum over row and col of |cur(row,col) - win(8+dx+col, 8+dy+row)|, where win(x,y) is a pixel of the 32x32 window.
- R5: Candidate 0 is the centre. Candidates 1 to 8 have (ox,oy) = (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1), in that order. The candidate with the smallest SAD becomes the next centre, and a tie goes to the lowest index.
- R6: Window pixel (x,y) is stored in bank (x mod 3)+3*(y mod 3), at address (y div 3)*11+(x div 3). Bank b uses `win_addr_o[7b+6:7b]` for its address and `win_pix_i[8b+7:8b]` for its data, and its data is valid in the same cycle as the address. Every bank serves exactly one candidate in every search cycle.
- R7: `mv_x_o` and `mv_y_o` are 4-bit two's-complement values within ±7, and `sad_o` is the SAD at that final vector. All three hold until the next search completes.
- R8: `start_i` has no effect while a search is in progress.
- R9: SADs are 16 bits wide and do not wrap. The largest possible value, 65280, is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| cur_addr_o | output | 8 | Current-block read address, row*16+col |
| cur_pix_i | input | 8 | Current-block pixel at `cur_addr_o` |
| win_addr_o | output | 63 | Nine 7-bit bank read addresses |
| win_pix_i | input | 72 | Nine 8-bit bank read data |
| done_o | output | 1 | One-cycle completion pulse |
| mv_x_o | output | 4 | Horizontal motion vector, signed |
| mv_y_o | output | 4 | Vertical motion vector, signed |
| sad_o | output | 16 | SAD at the final motion vector |

## Verification
On the last pixel of each step, two things happen on the same clock edge. The final absolute difference is still being added to every unit, and the minimum is being chosen from those totals to move the centre. If either one were evaluated a cycle apart, the step would compare incomplete sums, so every step boundary would be exposed.

A second coincidence is a `start_i` pulse that arrives while a search is running. The bench raises it in the middle of one run. It then requires the completion pulse on the original cycle and the same vector and SAD that a behavioural three-step search over the same images produces.

A per-cycle model also checks the raster address and the exact position of the done pulse. The test images are random, shifted, flat and extreme. The flat and extreme images make all nine SADs equal, which exercises the tie order.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;
  localparam int unsigned NCAND = 9;  // centre + eight neighbours
  localparam int unsigned NGRID = 3;  // banks per axis

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  function automatic int cand_dx(int k);
    case (k)
      1, 4, 6: return -1;
      3, 5, 8: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int cand_dy(int k);
    case (k)
      1, 2, 3: return -1;
      6, 7, 8: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tss_addr_gen.sv
`timescale 1ns/1ps
module tss_addr_gen
  import tss_pkg::*;
#(
  parameter int K      = 0,
  parameter int BLK_W  = 4,
  parameter int MV_W   = 4,
  parameter int NSTEP  = 3,
  parameter int STEP_W = 2,
  parameter int WIN    = 32,
  parameter int AW     = 7,
  parameter int BANK_W = 4
) (
  input  logic signed [MV_W-1:0]   cx_i,
  input  logic signed [MV_W-1:0]   cy_i,
  input  logic        [STEP_W-1:0] step_i,
  input  logic        [BLK_W-1:0]  col_i,
  input  logic        [BLK_W-1:0]  row_i,
  output logic        [BANK_W-1:0] bank_o,
  output logic        [AW-1:0]     addr_o
);
  localparam int ORIGIN = 1 << NSTEP;
  localparam int WIN_Q  = (WIN + NGRID - 1) / NGRID;

  always_comb begin
    int d, px, py;
    d  = (1 << (NSTEP - 1)) >> step_i;
    px = ORIGIN + int'(cx_i) + cand_dx(K) * d + int'(col_i);
    py = ORIGIN + int'(cy_i) + cand_dy(K) * d + int'(row_i);
    // 3x3 tiling: any three points spaced 1, 2 or 4 apart differ mod 3
    bank_o = BANK_W'((px % NGRID) + NGRID * (py % NGRID));
    addr_o = AW'((py / NGRID) * WIN_Q + px / NGRID);
  end
endmodule

// File: rtl/tss_sad_pe.sv
`timescale 1ns/1ps
module tss_sad_pe #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  output logic [SAD_W-1:0] sum_o
);
  logic [SAD_W-1:0] acc_q;
  logic [PIX_W-1:0] diff;

  assign diff  = (a_i > b_i) ? a_i - b_i : b_i - a_i;
  assign sum_o = (clr_i ? '0 : acc_q) + SAD_W'(diff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end

  // first pixel of a step restarts the sum
  p_step_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (acc_q < SAD_W'(1 << PIX_W)));
  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/tss_min_sel.sv
`timescale 1ns/1ps
module tss_min_sel #(
  parameter int NC    = 9,
  parameter int SAD_W = 16,
  parameter int IDX_W = 4
) (
  input  logic [SAD_W-1:0] sad_i [NC],
  output logic [IDX_W-1:0] idx_o,
  output logic [SAD_W-1:0] min_o
);
  always_comb begin
    idx_o = '0;
    min_o = sad_i[0];
    for (int k = 1; k < NC; k++) begin
      if (sad_i[k] < min_o) begin  // strict: lower index keeps ties
        min_o = sad_i[k];
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tss_me.sv
`timescale 1ns/1ps
module tss_me
  import tss_pkg::*;
#(
  parameter  int PIX_W  = 8,
  parameter  int BLK    = 16,
  parameter  int NSTEP  = 3,
  parameter  int SAD_W  = 16,
  localparam int BLK_W  = $clog2(BLK),
  localparam int CNT_W  = 2 * BLK_W,
  localparam int MV_W   = NSTEP + 1,
  localparam int ORIGIN = 1 << NSTEP,
  localparam int WIN    = BLK + 2 * ORIGIN,
  localparam int WIN_Q  = (WIN + NGRID - 1) / NGRID,
  localparam int NBANK  = NGRID * NGRID,
  localparam int AW     = $clog2(WIN_Q * WIN_Q),
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(NCAND),
  localparam int STEP_W = $clog2(NSTEP)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic [CNT_W-1:0]        cur_addr_o,
  input  logic [PIX_W-1:0]        cur_pix_i,
  output logic [NBANK*AW-1:0]     win_addr_o,
  input  logic [NBANK*PIX_W-1:0]  win_pix_i,
  output logic                    done_o,
  output logic signed [MV_W-1:0]  mv_x_o,
  output logic signed [MV_W-1:0]  mv_y_o,
  output logic [SAD_W-1:0]        sad_o
);
  state_e                   state_q;
  logic [STEP_W-1:0]        step_q;
  logic [CNT_W-1:0]         pix_q;
  logic signed [MV_W-1:0]   cx_q, cy_q, nx, ny;
  logic                     running, last_pix, last_step;

  logic [BANK_W-1:0] c_bank [NCAND];
  logic [AW-1:0]     c_addr [NCAND];
  logic [PIX_W-1:0]  c_pix  [NCAND];
  logic [SAD_W-1:0]  c_sum  [NCAND];
  logic [IDX_W-1:0]  best_idx;
  logic [SAD_W-1:0]  best_sad;

  assign running    = (state_q == ST_RUN);
  assign last_pix   = &pix_q;
  assign last_step  = (step_q == STEP_W'(NSTEP - 1));
  assign cur_addr_o = pix_q;

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    tss_addr_gen #(
      .K(k), .BLK_W(BLK_W), .MV_W(MV_W), .NSTEP(NSTEP), .STEP_W(STEP_W),
      .WIN(WIN), .AW(AW), .BANK_W(BANK_W)
    ) u_ag (
      .cx_i(cx_q), .cy_i(cy_q), .step_i(step_q),
      .col_i(pix_q[BLK_W-1:0]), .row_i(pix_q[CNT_W-1:BLK_W]),
      .bank_o(c_bank[k]), .addr_o(c_addr[k])
    );

    assign c_pix[k] = win_pix_i[c_bank[k]*PIX_W +: PIX_W];

    tss_sad_pe #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(running), .clr_i(pix_q == '0),
      .a_i(cur_pix_i), .b_i(c_pix[k]), .sum_o(c_sum[k])
    );
  end

  // bank crossbar: each bank takes the address of the one candidate mapped to it
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NCAND-1:0] hit;
    logic [AW-1:0]    addr;
    always_comb begin
      addr = '0;
      for (int k = 0; k < NCAND; k++) begin
        hit[k] = (c_bank[k] == BANK_W'(b));
        if (hit[k]) addr = addr | c_addr[k];
      end
    end
    assign win_addr_o[b*AW +: AW] = addr;

    p_bank_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      running |-> $onehot(hit));
  end

  tss_min_sel #(.NC(NCAND), .SAD_W(SAD_W), .IDX_W(IDX_W)) u_min (
    .sad_i(c_sum), .idx_o(best_idx), .min_o(best_sad)
  );

  always_comb begin
    int d;
    d  = (1 << (NSTEP - 1)) >> step_q;
    nx = MV_W'(int'(cx_q) + cand_dx(int'(best_idx)) * d);
    ny = MV_W'(int'(cy_q) + cand_dy(int'(best_idx)) * d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      pix_q   <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
      done_o  <= 1'b0;
      mv_x_o  <= '0;
      mv_y_o  <= '0;
      sad_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!running) begin
        if (start_i) begin
          state_q <= ST_RUN;
          step_q  <= '0;
          pix_q   <= '0;
          cx_q    <= '0;
          cy_q    <= '0;
        end
      end else begin
        pix_q <= pix_q + CNT_W'(1);
        if (last_pix) begin
          step_q <= step_q + STEP_W'(1);
          cx_q   <= nx;
          cy_q   <= ny;
          if (last_step) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            mv_x_o  <= nx;
            mv_y_o  <= ny;
            sad_o   <= best_sad;
          end
        end
      end
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_pix_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !last_pix) |=> (running && pix_q == $past(pix_q) + CNT_W'(1)));
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && start_i && !last_pix) |=>
      (step_q == $past(step_q) && cx_q == $past(cx_q) && cy_q == $past(cy_q)));
  p_mv_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(mv_x_o) >= 1 - ORIGIN && int'(mv_x_o) <= ORIGIN - 1 &&
                int'(mv_y_o) >= 1 - ORIGIN && int'(mv_y_o) <= ORIGIN - 1));
endmodule

// File: tb/test_tss_me.sv
`timescale 1ns/1ps
module test_tss_me;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [7:0]         cur_addr;
  logic [7:0]         cur_pix;
  logic [62:0]        win_addr;
  logic [71:0]        win_pix;
  logic               done;
  logic signed [3:0]  mv_x, mv_y;
  logic [15:0]        sad;

  always #5 clk = ~clk;

  tss_me i_tss_me (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .cur_addr_o(cur_addr), .cur_pix_i(cur_pix),
    .win_addr_o(win_addr), .win_pix_i(win_pix),
    .done_o(done), .mv_x_o(mv_x), .mv_y_o(mv_y), .sad_o(sad)
  );

  logic [7:0] cur_m [256];
  logic [7:0] win_m [1024];  // index y*32+x

  always_comb cur_pix = cur_m[cur_addr];

  // banked window model per R6
  always_comb begin
    for (int b = 0; b < 9; b++) begin
      int a, px, py;
      a  = int'(win_addr[b*7 +: 7]);
      py = (a / 11) * 3 + b / 3;
      px = (a % 11) * 3 + b % 3;
      win_pix[b*8 +: 8] = (px < 32 && py < 32) ? win_m[py*32 + px] : 8'h00;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sad(input int dx, input int dy);
    int s = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        int va = int'(cur_m[r*16 + c]);
        int vb = int'(win_m[(8 + dy + r)*32 + 8 + dx + c]);
        s += (va > vb) ? va - vb : vb - va;
      end
    return s;
  endfunction

  task automatic ref_tss(output int mx, output int my, output int sd);
    int ox[9] = '{0, -1, 0, 1, -1, 1, -1, 0, 1};
    int oy[9] = '{0, -1, -1, -1, 0, 0, 1, 1, 1};
    int cx = 0, cy = 0;
    sd = 0;
    for (int s = 4; s >= 1; s = s / 2) begin
      int bs, tx, ty;
      bs = ref_sad(cx, cy); tx = cx; ty = cy;
      for (int k = 1; k < 9; k++) begin
        int v = ref_sad(cx + ox[k]*s, cy + oy[k]*s);
        if (v < bs) begin bs = v; tx = cx + ox[k]*s; ty = cy + oy[k]*s; end
      end
      cx = tx; cy = ty; sd = bs;
    end
    mx = cx; my = cy;
  endtask

  int unsigned lcg;
  function automatic logic [7:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  task automatic fill_random(input int unsigned seed);
    lcg = seed;
    for (int i = 0; i < 1024; i++) win_m[i] = rnd();
    for (int i = 0; i < 256; i++) cur_m[i] = rnd();
  endtask

  task automatic fill_const(input logic [7:0] a, input logic [7:0] w);
    for (int i = 0; i < 1024; i++) win_m[i] = w;
    for (int i = 0; i < 256; i++) cur_m[i] = a;
  endtask

  // poke: cycle index at which start_i is raised mid-run, -1 for none
  task automatic run_search(input string tag, input int poke);
    int ex, ey, es;
    ref_tss(ex, ey, es);
    @(negedge clk); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk); start_i = 1'b0;
    for (int n = 0; n < 768; n++) begin
      check(cur_addr == 8'(n % 256), {"R3 addr ", tag}, int'(cur_addr), n % 256);
      check(done == 1'b0, {"R2 early done ", tag}, int'(done), 0);
      start_i = (n == poke);  // R8 stimulus
      @(negedge clk);
    end
    start_i = 1'b0;
    check(done == 1'b1, {"R2 done ", tag}, int'(done), 1);
    check(int'(mv_x) == ex, {"R4 R5 mv_x ", tag}, int'(mv_x), ex);
    check(int'(mv_y) == ey, {"R4 R5 mv_y ", tag}, int'(mv_y), ey);
    check(int'(sad) == es, {"R7 R9 sad ", tag}, int'(sad), es);
    @(negedge clk);
    check(done == 1'b0, {"R2 pulse width ", tag}, int'(done), 0);
    check(int'(mv_x) == ex && int'(mv_y) == ey && int'(sad) == es,
          {"R7 hold ", tag}, int'(sad), es);
  endtask

  initial begin
    fill_const(8'd0, 8'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(mv_x == 4'sd0 && mv_y == 4'sd0, "R1 mv", int'(mv_x), 0);
    check(sad == 16'd0, "R1 sad", int'(sad), 0);

    fill_random(32'd1);
    run_search("random1", -1);

    fill_random(32'd7);
    run_search("random2 start poke R8", 300);

    fill_random(32'd3);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        cur_m[r*16 + c] = win_m[(8 - 5 + r)*32 + 8 + 3 + c];
    run_search("shifted", -1);

    fill_const(8'd77, 8'd77);
    run_search("flat tie R5", -1);
    check(mv_x == 4'sd0 && mv_y == 4'sd0, "R5 tie keeps centre", int'(mv_x), 0);

    fill_const(8'd255, 8'd0);
    run_search("max R9", 0);
    check(sad == 16'd65280, "R9 max sad", int'(sad), 65280);

    fill_random(32'd11);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        cur_m[r*16 + c] = win_m[(8 + 7 + r)*32 + 8 - 7 + c];
    run_search("corner", -1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule